// File: doc/BRIEF.md
# Display Controller Command Parser

This block sits behind the byte receiver of a serial display link and interprets each received byte, steered by a select line. With the select line low a byte is command traffic: the first byte is an opcode, and the opcode sets how many argument bytes follow, from none to eight. Once the last argument arrives the parser updates the addressing state. That state is the column window, the row window, the current write position and a remap byte. With the select line high a byte is pixel data. The block then issues a one-cycle write strobe carrying the current position and the byte, and steps the position through the window.

Opcodes that tune the panel's analog behaviour are recognised so that their argument bytes are consumed. They are never mistaken for opcodes, and they change no state. An unrecognised opcode gives a one-cycle error pulse, and the parser goes back to waiting for an opcode. The serial shifter, the pixel memory and the panel drive are outside this block.

Top module: `disp_cmd_parser`

## Requirements
- R1: After reset the column window is 0..63, the row window is 0..79, the current position is column 0 and row 0, the remap byte is 0, and the write strobe and error pulse are low.
- R2: Opcode 0x15 followed by two bytes sets the column window start to the first byte mod 64 and the end to the second byte mod 64. The current column moves to the new start.
- R3: Opcode 0x75 followed by two bytes sets the row window start to the first byte mod 80 and the end to the second byte mod 80. The current row moves to the new start. The current row never reaches 80.
- R4: Opcode 0xA0 stores its single argument byte as the remap byte. Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each consume one argument byte and change nothing, even when that byte has an opcode's value.
- R5: Opcode 0xB8 consumes the next eight command bytes and changes nothing.
- R6: Opcodes 0x84, 0x85, 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 complete on the opcode byte itself, so the next command byte is an opcode.
- R7: A byte of 0xFF in opcode position is dropped without an error pulse, and the next command byte is an opcode.
- R8: Any other opcode value raises the error output for exactly the cycle after that byte is taken. The next command byte is then an opcode.
- R9: A byte taken with select high raises the write strobe for the following cycle. In that cycle the write column and write row show the position held before the byte, and the write data shows the byte. Data bytes never change the windows or the remap byte.
- R10: With remap bit 2 clear, each data byte moves the column forward by one. From a column at or past the column end, the column returns to the column start and the row steps forward. From a row at or past the row end, the row returns to the row start.
- R11: With remap bit 2 set, the roles swap: the row steps forward first, and at the row end the row wraps to its start while the column steps forward, wrapping the same way.
- R12: A change of level on the select line drops any partly received command. Its stored arguments are never applied, and a command byte taken after the change is treated as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | Received byte |
| sel_data | input | 1 | 0: command traffic, 1: pixel data |
| col_start | output | 6 | Column window start |
| col_end | output | 6 | Column window end |
| row_start | output | 7 | Row window start |
| row_end | output | 7 | Row window end |
| cur_col | output | 6 | Current write column |
| cur_row | output | 7 | Current write row |
| remap | output | 8 | Stored remap byte |
| wr_strobe | output | 1 | One-cycle pixel write request |
| wr_col | output | 6 | Column of the pending write |
| wr_row | output | 7 | Row of the pending write |
| wr_data | output | 8 | Byte of the pending write |
| bad_op | output | 1 | One-cycle unknown-opcode pulse |

## Verification
A wrong argument count does not stay hidden. The byte that should have been an opcode is read as an argument, or an argument is read as an opcode. This shows up one cycle later as a spurious error pulse or as window registers that did not move. The bench therefore follows every swallowing opcode with a window command and reads the windows back. A cursor that steps wrongly appears on the write address of the very next data byte. Each pixel write is compared against a position model kept in the bench, so a fault shows within one byte of its cause.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  typedef enum logic [2:0] {
    K_COL   = 3'd0,
    K_ROW   = 3'd1,
    K_REMAP = 3'd2,
    K_SKIP  = 3'd3,
    K_PAD   = 3'd4,
    K_BAD   = 3'd5
  } op_kind_t;

  localparam int unsigned VERT_BIT  = 2;
  localparam logic [7:0]  OP_COLWIN = 8'h15;
  localparam logic [7:0]  OP_ROWWIN = 8'h75;
  localparam logic [7:0]  OP_REMAP  = 8'hA0;
  localparam logic [7:0]  OP_GREY   = 8'hB8;
  localparam logic [7:0]  OP_PAD    = 8'hFF;

  function automatic op_kind_t classify(input logic [7:0] op);
    op_kind_t k;
    case (op)
      OP_COLWIN: k = K_COL;
      OP_ROWWIN: k = K_ROW;
      OP_REMAP:  k = K_REMAP;
      OP_PAD:    k = K_PAD;
      8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF,
      OP_GREY,
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3: k = K_SKIP;
      default:   k = K_BAD;
    endcase
    return k;
  endfunction

  function automatic logic [3:0] arg_count(input logic [7:0] op);
    logic [3:0] n;
    case (op)
      OP_COLWIN, OP_ROWWIN: n = 4'd2;
      OP_GREY:              n = 4'd8;
      OP_REMAP, 8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: n = 4'd1;
      default:              n = 4'd0;
    endcase
    return n;
  endfunction

  function automatic logic [7:0] fold(input logic [7:0] v, input int unsigned lim);
    return 8'(32'(v) % lim);
  endfunction

endpackage

// File: rtl/dcp_decode.sv
module dcp_decode
  import dcp_pkg::*;
(
  input  logic [7:0] op,
  output op_kind_t   kind,
  output logic [3:0] nargs
);
  always_comb begin
    kind  = classify(op);
    nargs = arg_count(op);
  end
endmodule

// File: rtl/dcp_seq.sv
module dcp_seq
  import dcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic       sel_data,
  input  logic [7:0] byte_data,
  input  op_kind_t   dec_kind,
  input  logic [3:0] dec_nargs,
  output logic       busy,
  output logic       sel_chg,
  output logic       apply,
  output op_kind_t   apply_kind,
  output logic [7:0] arg_first,
  output logic [7:0] arg_last,
  output logic       bad_now
);
  logic       sel_q;
  op_kind_t   pend_kind;
  logic [3:0] need;
  logic [3:0] got;
  logic [7:0] first_q;
  logic       cmd_byte;
  logic       idle_eff;
  logic       start;
  logic       opens;

  // Tracks the select level seen at the previous edge, reset or not.
  always_ff @(posedge clk) sel_q <= sel_data;

  always_comb begin
    sel_chg    = (sel_data != sel_q);
    cmd_byte   = byte_valid && !sel_data;
    idle_eff   = !busy || sel_chg;
    start      = cmd_byte && idle_eff;
    bad_now    = start && (dec_kind == K_BAD);
    opens      = start && (dec_kind != K_BAD) && (dec_kind != K_PAD) && (dec_nargs != 4'd0);
    apply      = cmd_byte && !idle_eff && (got == need - 4'd1);
    apply_kind = pend_kind;
    arg_first  = (got == 4'd0) ? byte_data : first_q;
    arg_last   = byte_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend_kind <= K_SKIP;
      need      <= 4'd0;
      got       <= 4'd0;
      first_q   <= 8'd0;
    end else if (start) begin
      busy <= opens;
      got  <= 4'd0;
      if (opens) begin
        pend_kind <= dec_kind;
        need      <= dec_nargs;
      end
    end else if (cmd_byte && busy) begin
      if (got == 4'd0) first_q <= byte_data;
      if (apply) busy <= 1'b0;
      else       got  <= got + 4'd1;
    end else if (sel_chg) begin
      busy <= 1'b0;
      got  <= 4'd0;
    end
  end
endmodule

// File: rtl/dcp_window.sv
module dcp_window
  import dcp_pkg::*;
#(
  parameter int unsigned COLS = 64,
  parameter int unsigned ROWS = 80,
  localparam int unsigned CW = $clog2(COLS),
  localparam int unsigned RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  op_kind_t      apply_kind,
  input  logic [7:0]    arg_first,
  input  logic [7:0]    arg_last,
  input  logic          wr_go,
  input  logic [7:0]    wr_byte,
  output logic [CW-1:0] col_start,
  output logic [CW-1:0] col_end,
  output logic [RW-1:0] row_start,
  output logic [RW-1:0] row_end,
  output logic [CW-1:0] cur_col,
  output logic [RW-1:0] cur_row,
  output logic [7:0]    remap,
  output logic          wr_strobe,
  output logic [CW-1:0] wr_col,
  output logic [RW-1:0] wr_row,
  output logic [7:0]    wr_data
);
  logic [7:0]    c_first, c_last, r_first, r_last;
  logic          col_at_end, row_at_end;
  logic [CW-1:0] col_step;
  logic [RW-1:0] row_step;

  always_comb begin
    c_first    = fold(arg_first, COLS);
    c_last     = fold(arg_last, COLS);
    r_first    = fold(arg_first, ROWS);
    r_last     = fold(arg_last, ROWS);
    col_at_end = (cur_col >= col_end);
    row_at_end = (cur_row >= row_end);
    col_step   = col_at_end ? col_start : cur_col + 1'b1;
    row_step   = row_at_end ? row_start : cur_row + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_start <= '0;
      col_end   <= CW'(COLS - 1);
      row_start <= '0;
      row_end   <= RW'(ROWS - 1);
      cur_col   <= '0;
      cur_row   <= '0;
      remap     <= 8'd0;
      wr_strobe <= 1'b0;
      wr_col    <= '0;
      wr_row    <= '0;
      wr_data   <= 8'd0;
    end else begin
      wr_strobe <= wr_go;
      if (apply) begin
        case (apply_kind)
          K_COL: begin
            col_start <= c_first[CW-1:0];
            col_end   <= c_last[CW-1:0];
            cur_col   <= c_first[CW-1:0];
          end
          K_ROW: begin
            row_start <= r_first[RW-1:0];
            row_end   <= r_last[RW-1:0];
            cur_row   <= r_first[RW-1:0];
          end
          K_REMAP: remap <= arg_first;
          default: ;
        endcase
      end else if (wr_go) begin
        wr_col  <= cur_col;
        wr_row  <= cur_row;
        wr_data <= wr_byte;
        if (remap[VERT_BIT]) begin
          cur_row <= row_step;
          if (row_at_end) cur_col <= col_step;
        end else begin
          cur_col <= col_step;
          if (col_at_end) cur_row <= row_step;
        end
      end
    end
  end
endmodule

// File: rtl/disp_cmd_parser.sv
module disp_cmd_parser
  import dcp_pkg::*;
#(
  parameter int unsigned COLS = 64,
  parameter int unsigned ROWS = 80,
  localparam int unsigned CW = $clog2(COLS),
  localparam int unsigned RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic          sel_data,
  output logic [CW-1:0] col_start,
  output logic [CW-1:0] col_end,
  output logic [RW-1:0] row_start,
  output logic [RW-1:0] row_end,
  output logic [CW-1:0] cur_col,
  output logic [RW-1:0] cur_row,
  output logic [7:0]    remap,
  output logic          wr_strobe,
  output logic [CW-1:0] wr_col,
  output logic [RW-1:0] wr_row,
  output logic [7:0]    wr_data,
  output logic          bad_op
);
  op_kind_t   dec_kind;
  logic [3:0] dec_nargs;
  logic       seq_busy, sel_chg, apply, bad_now, wr_go;
  op_kind_t   apply_kind;
  logic [7:0] arg_first, arg_last;

  dcp_decode u_dec (.op(byte_data), .kind(dec_kind), .nargs(dec_nargs));

  dcp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .sel_data(sel_data),
    .byte_data(byte_data), .dec_kind(dec_kind), .dec_nargs(dec_nargs),
    .busy(seq_busy), .sel_chg(sel_chg), .apply(apply), .apply_kind(apply_kind),
    .arg_first(arg_first), .arg_last(arg_last), .bad_now(bad_now)
  );

  assign wr_go = byte_valid && sel_data;

  dcp_window #(.COLS(COLS), .ROWS(ROWS)) u_win (
    .clk(clk), .rst_n(rst_n), .apply(apply), .apply_kind(apply_kind),
    .arg_first(arg_first), .arg_last(arg_last), .wr_go(wr_go), .wr_byte(byte_data),
    .col_start(col_start), .col_end(col_end), .row_start(row_start), .row_end(row_end),
    .cur_col(cur_col), .cur_row(cur_row), .remap(remap), .wr_strobe(wr_strobe),
    .wr_col(wr_col), .wr_row(wr_row), .wr_data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bad_op <= 1'b0;
    else        bad_op <= bad_now;
  end
endmodule

// File: rtl/dcp_checker.sv
module dcp_checker #(
  parameter int unsigned CW = 6,
  parameter int unsigned RW = 7,
  parameter int unsigned ROWS = 80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_valid,
  input logic          sel_data,
  input logic          wr_strobe,
  input logic          bad_op,
  input logic          seq_busy,
  input logic [CW-1:0] col_start,
  input logic [CW-1:0] col_end,
  input logic [RW-1:0] row_start,
  input logic [RW-1:0] row_end,
  input logic [RW-1:0] cur_row,
  input logic [7:0]    remap
);
  p_wr_from_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(byte_valid && sel_data));

  p_err_from_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> $past(byte_valid && !sel_data));

  p_data_keeps_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(byte_valid && sel_data) |-> ($stable(col_start) && $stable(col_end) &&
                                       $stable(row_start) && $stable(row_end) && $stable(remap)));

  p_remap_by_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(remap) |-> $past(byte_valid && !sel_data));

  p_row_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cur_row) < ROWS) && (32'(row_start) < ROWS) && (32'(row_end) < ROWS));

  p_sel_flip_drops_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_valid && (sel_data != $past(sel_data))) |=> !seq_busy);
endmodule

bind disp_cmd_parser dcp_checker #(.CW(CW), .RW(RW), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .sel_data(sel_data),
  .wr_strobe(wr_strobe), .bad_op(bad_op), .seq_busy(seq_busy),
  .col_start(col_start), .col_end(col_end), .row_start(row_start), .row_end(row_end),
  .cur_row(cur_row), .remap(remap)
);

// File: tb/sim_disp_cmd_parser.sv
`timescale 1ns/1ps
module sim_disp_cmd_parser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'd0;
  logic sel_data = 1'b0;
  logic [5:0] col_start, col_end, cur_col, wr_col;
  logic [6:0] row_start, row_end, cur_row, wr_row;
  logic [7:0] remap, wr_data;
  logic wr_strobe, bad_op;

  always #5 clk = ~clk;

  disp_cmd_parser u0 (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .sel_data(sel_data), .col_start(col_start), .col_end(col_end),
    .row_start(row_start), .row_end(row_end), .cur_col(cur_col), .cur_row(cur_row),
    .remap(remap), .wr_strobe(wr_strobe), .wr_col(wr_col), .wr_row(wr_row),
    .wr_data(wr_data), .bad_op(bad_op)
  );

  int checks = 0;
  int errors = 0;
  int exp_bad = 0;
  int seen_bad = 0;
  bit done = 0;
  logic [20:0] sb_q[$];

  // bench position model
  int m_cs = 0, m_ce = 63, m_rs = 0, m_re = 79, m_c = 0, m_r = 0;
  bit m_vert = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic sel, input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1; sel_data = sel; byte_data = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    put(1'b0, b);
  endtask

  task automatic pix(input logic [7:0] b);
    sb_q.push_back({7'(m_r), 6'(m_c), b});
    if (!m_vert) begin
      if (m_c < m_ce) m_c++;
      else begin
        m_c = m_cs;
        m_r = (m_r < m_re) ? m_r + 1 : m_rs;
      end
    end else begin
      if (m_r < m_re) m_r++;
      else begin
        m_r = m_rs;
        m_c = (m_c < m_ce) ? m_c + 1 : m_cs;
      end
    end
    put(1'b1, b);
  endtask

  task automatic set_cols(input logic [7:0] a, input logic [7:0] b);
    cmd(8'h15); cmd(a); cmd(b);
    m_cs = a % 64; m_ce = b % 64; m_c = m_cs;
  endtask

  task automatic set_rows(input logic [7:0] a, input logic [7:0] b);
    cmd(8'h75); cmd(a); cmd(b);
    m_rs = a % 80; m_re = b % 80; m_r = m_rs;
  endtask

  task automatic win_chk(input string req);
    chk({req, " col_start"}, col_start, m_cs);
    chk({req, " col_end"}, col_end, m_ce);
    chk({req, " row_start"}, row_start, m_rs);
    chk({req, " row_end"}, row_end, m_re);
    chk({req, " cur_col"}, cur_col, m_c);
    chk({req, " cur_row"}, cur_row, m_r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && wr_strobe) begin
      if (sb_q.size() == 0) chk("R9 unexpected write", 1, 0);
      else begin
        logic [20:0] e;
        e = sb_q.pop_front();
        chk("R9/R10/R11 wr_row", wr_row, e[20:14]);
        chk("R9/R10/R11 wr_col", wr_col, e[13:8]);
        chk("R9 wr_data", wr_data, e[7:0]);
      end
    end
    if (rst_n && bad_op) seen_bad++;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    win_chk("R1");
    chk("R1 remap", remap, 0);
    chk("R1 wr_strobe", wr_strobe, 0);
    chk("R1 bad_op", bad_op, 0);

    // R2 / R3 windows
    set_cols(8'h02, 8'h05);
    set_rows(8'h01, 8'h02);
    win_chk("R2/R3 small window");

    // R9 / R10 horizontal writes with wrap
    for (int i = 0; i < 10; i++) pix(8'(8'h30 + i));
    win_chk("R10 after horizontal run");

    // R2 / R3 modulo reduction
    set_cols(8'h47, 8'hFF);
    set_rows(8'h55, 8'hA0);
    win_chk("R2/R3 modulo");
    chk("R2 col start 0x47 mod 64", col_start, 7);
    chk("R3 row start 0x55 mod 80", row_start, 5);

    // R4 one-argument swallow: argument looks like an opcode
    cmd(8'h81); cmd(8'h15);
    cmd(8'hBE); cmd(8'h75);
    win_chk("R4 swallowed args");
    chk("R4 remap untouched", remap, 0);
    chk("R4/R8 no error from swallowed", seen_bad, exp_bad);

    // R5 grey table eight args
    cmd(8'hB8);
    for (int i = 0; i < 8; i++) cmd(8'h75);
    set_cols(8'h03, 8'h09);
    win_chk("R5 after eight swallowed");

    // R6 zero-argument opcodes
    cmd(8'hA4); cmd(8'hE3); cmd(8'hAF); cmd(8'h85);
    set_rows(8'h04, 8'h06);
    win_chk("R6 zero-arg");

    // R7 pad byte
    cmd(8'hFF);
    set_cols(8'h00, 8'h01);
    win_chk("R7 pad ignored");
    chk("R7 no error", seen_bad, exp_bad);

    // R8 unknown opcode
    cmd(8'h00);
    chk("R8 error pulse", bad_op, 1);
    exp_bad++;
    @(negedge clk);
    chk("R8 pulse one cycle", bad_op, 0);
    set_rows(8'h00, 8'h02);
    win_chk("R8 resync");

    // R4 remap store, R11 vertical stepping
    cmd(8'hA0); cmd(8'h04);
    chk("R4 remap stored", remap, 4);
    m_vert = 1;
    for (int i = 0; i < 7; i++) pix(8'(8'hC0 + i));
    win_chk("R11 after vertical run");

    // R12 select change drops partial command
    cmd(8'hA0); cmd(8'h00);
    m_vert = 0;
    cmd(8'h15); cmd(8'h20);
    pix(8'h5A);
    win_chk("R12 partial dropped");
    set_cols(8'h0A, 8'h14);
    win_chk("R12 fresh opcode");
    // select flips low with a byte: treated as opcode
    cmd(8'h75); cmd(8'h03);
    @(negedge clk); sel_data = 1'b1;
    @(negedge clk); sel_data = 1'b0;
    set_rows(8'h02, 8'h07);
    win_chk("R12 idle flip");

    repeat (4) @(negedge clk);
    chk("R9 scoreboard drained", sb_q.size(), 0);
    chk("R8 error count", seen_bad, exp_bad);
    finish_run();
  end
endmodule